// File: doc/BRIEF.md
# Pin Edge Interrupt Controller

This block watches a parameterised set of general-purpose input pins, up to 64 of them. It flags a single chosen edge on each pin: rising or falling, selected by a per-pin polarity bit. Every detected edge sets a sticky status bit. Software reads these bits and clears them by writing ones, through a flat word-addressed register port with address, write data, write strobe and combinational read data. Per-pin enable bits gate the status bits onto one combined interrupt line. A separate set of per-pin wake-enable bits gates the same status bits onto one combined wake line.

Pins are grouped into 32-pin banks. Each register type occupies two consecutive words, one per bank. The hardware has no both-edge mode. Software gets both-edge behaviour by flipping a pin's polarity bit after each event, so a polarity change on its own never counts as an edge.

Each pin is sampled through a synchroniser chain. After reset, a small start-up sequencer keeps detection off until the synchroniser holds real pin levels and the edge-history register has been loaded from them. The sequencer has three states:
- ST_FILL: counts SYNC_STAGES cycles while the chain fills, then moves to ST_ARM.
- ST_ARM: one cycle in which the history loads from a valid sample, then moves to ST_RUN.
- ST_RUN: detection active; the sequencer stays here until reset.

Top module: `pin_edge_irq_ctrl`

## Requirements
- R1: Register words are decoded from address bits [4:2]. Bits [4:3] select the register: 0 enable, 1 polarity, 2 status, 3 wake-enable, so the low-bank words sit at 0x00, 0x08, 0x10 and 0x18. Bit 2 selects the bank: 0 for pins 0..31, 1 for pins 32 and up, so each high-bank word sits 4 above its low-bank word. Pin p maps to bit p mod 32. Address bits [1:0] are ignored.
- R2: Enable, polarity and wake-enable are read/write: a write replaces all existing bits of the addressed bank word, and a read returns them.
- R3: Polarity 0 detects a rising edge and polarity 1 a falling edge. A pin change driven just after one rising clock edge shows in the status register after the third rising clock edge. The opposite edge sets nothing.
- R4: A detected edge sets its status bit whether or not the pin's enable bit is set. The bit then stays set until software clears it.
- R5: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as a clear of that bit, the bit remains set.
- R6: The interrupt output is high exactly when some pin has both its status bit and its enable bit set.
- R7: The wake output is high exactly when some pin has both its status bit and its wake-enable bit set.
- R8: Changing a polarity bit while the pin is steady produces no status event.
- R9: The pin count NUM_PINS is a parameter; 36 and 30 are both supported. Bits for absent pins read 0 and ignore writes.
- R10: Reset clears all four registers. Pin levels held steady across reset release produce no status event, whatever those levels are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Asynchronous pin levels |
| reg_addr | input | 5 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_out | output | 1 | Combined interrupt: any status bit with its enable set |
| wake_out | output | 1 | Combined wake: any status bit with its wake-enable set |

## Verification
The bench sweeps every pin of a 36-pin instance through both polarities and both edge directions. A bank-decode or bit-position error shows up as a status bit in the wrong word. A swapped polarity sense flags the wrong edge. Status that is not sticky loses the bit once the pin returns to its starting level.

Several corner cases get their own tests:
- A write-one-to-clear is timed to land in the very cycle an edge is detected. A design that gives the clear priority would lose that event.
- A polarity bit is toggled on steady pins. A design that compares old and new polarity would invent events.
- Reset is released with a mixed pin pattern. A design without the start-up sequencer would report false rising edges.
- A 30-pin instance checks that absent bits read zero, where a missing mask would echo the written data.

// File: rtl/pin_edge_pkg.sv
package pin_edge_pkg;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 5;

    typedef enum logic [1:0] {
        SEL_ENABLE   = 2'd0,
        SEL_POLARITY = 2'd1,
        SEL_STATUS   = 2'd2,
        SEL_WAKE     = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_FILL = 2'd0,
        ST_ARM  = 2'd1,
        ST_RUN  = 2'd2
    } arm_state_e;
endpackage

// File: rtl/pin_edge_sync.sv
module pin_edge_sync
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS    = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_raw,
    output logic [NUM_PINS-1:0] pin_now,
    output logic [NUM_PINS-1:0] pin_prev,
    output logic                run_ok
);
    localparam int CNT_W = $clog2(SYNC_STAGES + 1);
    localparam logic [CNT_W-1:0] FILL_LAST = CNT_W'(SYNC_STAGES - 1);

    logic [SYNC_STAGES-1:0][NUM_PINS-1:0] chain_q;
    logic [NUM_PINS-1:0]                  hist_q;
    arm_state_e                           state_q, state_d;
    logic [CNT_W-1:0]                     cnt_q, cnt_d;

    // synchroniser chain and edge history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            hist_q  <= '0;
        end else begin
            chain_q[0] <= pin_raw;
            for (int s = 1; s < SYNC_STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
            hist_q <= chain_q[SYNC_STAGES-1];
        end
    end

    // start-up sequencer: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // start-up sequencer: next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_FILL: begin
                if (cnt_q == FILL_LAST) begin
                    state_d = ST_ARM;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ARM:  state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // start-up sequencer: outputs
    always_comb begin
        run_ok = (state_q == ST_RUN);
    end

    assign pin_now  = chain_q[SYNC_STAGES-1];
    assign pin_prev = hist_q;
endmodule

// File: rtl/pin_edge_detect.sv
module pin_edge_detect #(
    parameter int NUM_PINS = 36
) (
    input  logic [NUM_PINS-1:0] pin_now,
    input  logic [NUM_PINS-1:0] pin_prev,
    input  logic [NUM_PINS-1:0] pol,
    input  logic                run_ok,
    output logic [NUM_PINS-1:0] edge_evt
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic rose, fell;
        assign rose        = pin_now[p] & ~pin_prev[p];
        assign fell        = ~pin_now[p] & pin_prev[p];
        assign edge_evt[p] = run_ok & (pol[p] ? fell : rose);
    end
endmodule

// File: rtl/pin_edge_regs.sv
module pin_edge_regs
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS = 36
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          word_sel,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic                reg_we,
    input  logic [NUM_PINS-1:0] edge_evt,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] en_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] stat_q,
    output logic [NUM_PINS-1:0] wake_q
);
    reg_sel_e            sel;
    logic                bank;
    logic [NUM_PINS-1:0] in_bank, wr_bits;
    logic [NUM_PINS-1:0] hit_en, hit_pol, hit_st, hit_wk;
    logic [NUM_PINS-1:0] en_d, pol_d, stat_d, wake_d, src;

    assign sel  = reg_sel_e'(word_sel[2:1]);
    assign bank = word_sel[0];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_map
        localparam logic BANK_BIT = ((p / WORD_W) == 1) ? 1'b1 : 1'b0;
        assign in_bank[p] = (bank == BANK_BIT);
        assign wr_bits[p] = reg_wdata[p % WORD_W];
    end

    assign hit_en  = {NUM_PINS{reg_we && (sel == SEL_ENABLE)}}   & in_bank;
    assign hit_pol = {NUM_PINS{reg_we && (sel == SEL_POLARITY)}} & in_bank;
    assign hit_st  = {NUM_PINS{reg_we && (sel == SEL_STATUS)}}   & in_bank;
    assign hit_wk  = {NUM_PINS{reg_we && (sel == SEL_WAKE)}}     & in_bank;

    assign en_d   = (en_q   & ~hit_en)  | (wr_bits & hit_en);
    assign pol_d  = (pol_q  & ~hit_pol) | (wr_bits & hit_pol);
    assign wake_d = (wake_q & ~hit_wk)  | (wr_bits & hit_wk);
    // new edge wins over a clear in the same cycle
    assign stat_d = (stat_q & ~(hit_st & wr_bits)) | edge_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            pol_q  <= '0;
            stat_q <= '0;
            wake_q <= '0;
        end else begin
            en_q   <= en_d;
            pol_q  <= pol_d;
            stat_q <= stat_d;
            wake_q <= wake_d;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE:   src = en_q;
            SEL_POLARITY: src = pol_q;
            SEL_STATUS:   src = stat_q;
            SEL_WAKE:     src = wake_q;
            default:      src = '0;
        endcase
        reg_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (in_bank[p]) begin
                reg_rdata[p % WORD_W] = src[p];
            end
        end
    end
endmodule

// File: rtl/pin_edge_irq_ctrl.sv
module pin_edge_irq_ctrl
    import pin_edge_pkg::*;
#(
    parameter int NUM_PINS    = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [WORD_W-1:0]   reg_wdata,
    input  logic                reg_we,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq_out,
    output logic                wake_out
);
    logic [NUM_PINS-1:0] pin_now, pin_prev, edge_evt;
    logic [NUM_PINS-1:0] en_vec, pol_vec, stat_vec, wake_vec;
    logic                run_ok;
    logic [1:0]          unused_addr_bits;

    assign unused_addr_bits = reg_addr[1:0];

    pin_edge_sync #(
        .NUM_PINS   (NUM_PINS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_raw (pin_in),
        .pin_now (pin_now),
        .pin_prev(pin_prev),
        .run_ok  (run_ok)
    );

    pin_edge_detect #(
        .NUM_PINS(NUM_PINS)
    ) u_detect (
        .pin_now (pin_now),
        .pin_prev(pin_prev),
        .pol     (pol_vec),
        .run_ok  (run_ok),
        .edge_evt(edge_evt)
    );

    pin_edge_regs #(
        .NUM_PINS(NUM_PINS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_sel (reg_addr[4:2]),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .edge_evt (edge_evt),
        .reg_rdata(reg_rdata),
        .en_q     (en_vec),
        .pol_q    (pol_vec),
        .stat_q   (stat_vec),
        .wake_q   (wake_vec)
    );

    assign irq_out  = |(stat_vec & en_vec);
    assign wake_out = |(stat_vec & wake_vec);
endmodule

// File: rtl/pin_edge_irq_checker.sv
module pin_edge_irq_checker #(
    parameter int NUM_PINS = 36
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_PINS-1:0] stat_vec,
    input logic [NUM_PINS-1:0] pin_now,
    input logic [NUM_PINS-1:0] pin_prev,
    input logic                run_ok,
    input logic [4:0]          reg_addr,
    input logic [31:0]         reg_rdata,
    input logic                reg_we,
    input logic                irq_out,
    input logic                wake_out
);
    localparam logic [63:0] LIVE = (NUM_PINS >= 64) ? {64{1'b1}}
                                                    : ((64'd1 << NUM_PINS) - 64'd1);
    logic [31:0] live_word;
    assign live_word = reg_addr[2] ? LIVE[63:32] : LIVE[31:0];

    AST_DEAD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rdata & ~live_word) == 32'd0); // R9
    AST_QUIET_STARTUP: assert property (@(posedge clk) disable iff (!rst_n) !run_ok |-> (stat_vec == '0)); // R10
    AST_SET_NEEDS_PIN_CHANGE: assert property (@(posedge clk) disable iff (!rst_n) (stat_vec & ~$past(stat_vec) & ~($past(pin_now) ^ $past(pin_prev))) == '0); // R8
    AST_STICKY_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !($past(reg_we) && ($past(reg_addr[4:3]) == 2'd2)) |-> (($past(stat_vec) & ~stat_vec) == '0)); // R4
    AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) irq_out |-> (stat_vec != '0)); // R6
    AST_WAKE_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n) wake_out |-> (stat_vec != '0)); // R7
endmodule

bind pin_edge_irq_ctrl pin_edge_irq_checker #(.NUM_PINS(NUM_PINS)) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_vec (stat_vec),
    .pin_now  (pin_now),
    .pin_prev (pin_prev),
    .run_ok   (run_ok),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .reg_we   (reg_we),
    .irq_out  (irq_out),
    .wake_out (wake_out)
);

// File: tb/pin_edge_irq_ctrl_bench.sv
`timescale 1ns/1ps
module pin_edge_irq_ctrl_bench;
    localparam logic [4:0] A_EN = 5'h00, A_POL = 5'h08, A_ST = 5'h10, A_WK = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [35:0] pins = '0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        we = 1'b0;
    logic [31:0] rdata36, rdata30;
    logic        irq36, wake36, irq30, wake30;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    pin_edge_irq_ctrl #(.NUM_PINS(36)) u_pin_edge_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_in(pins), .reg_addr(addr),
        .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata36),
        .irq_out(irq36), .wake_out(wake36));

    pin_edge_irq_ctrl #(.NUM_PINS(30)) u_pin_edge_irq_ctrl_small (
        .clk(clk), .rst_n(rst_n), .pin_in(pins[29:0]), .reg_addr(addr),
        .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata30),
        .irq_out(irq30), .wake_out(wake30));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd36(input logic [4:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata36;
    endtask

    task automatic rd30(input logic [4:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata30;
    endtask

    function automatic logic [31:0] bankw(input logic [35:0] v, input int b);
        return (b == 1) ? {28'd0, v[35:32]} : v[31:0];
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        logic [35:0] expv;
        // R10: reset with a mixed steady pattern on the pins
        pins = 36'h9_A5C3_0F61;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(8);
        for (int r = 0; r < 8; r++) begin
            rd36(5'(r * 4), d); chk("R10 reset value 36", d, 32'd0);
            rd30(5'(r * 4), d); chk("R10 reset value 30", d, 32'd0);
        end
        chk("R10 irq idle", {31'd0, irq36}, 32'd0);
        pins = '0;
        wait_n(4);
        wr(A_ST, '1); wr(A_ST + 5'd4, '1);

        // R1 R2 R9: read/write registers in both banks, both instances
        for (int r = 0; r < 4; r++) begin
            if (r == 2) continue;
            wr(5'(r * 8), 32'hDEAD_BEEF);
            wr(5'(r * 8 + 4), 32'hFFFF_FFFF);
            rd36(5'(r * 8), d);     chk("R2 low bank readback", d, 32'hDEAD_BEEF);
            rd36(5'(r * 8 + 3), d); chk("R1 low address bits ignored", d, 32'hDEAD_BEEF);
            rd36(5'(r * 8 + 4), d); chk("R9 high bank 36 pins", d, 32'h0000_000F);
            rd30(5'(r * 8), d);     chk("R9 low bank 30 pins", d, 32'h1EAD_BEEF);
            rd30(5'(r * 8 + 4), d); chk("R9 high bank 30 pins", d, 32'd0);
            wr(5'(r * 8), 32'd0);
            wr(5'(r * 8 + 4), 32'd0);
            rd36(5'(r * 8), d);     chk("R2 cleared readback", d, 32'd0);
        end
        wr(A_ST, '1); wr(A_ST + 5'd4, '1);
        rd36(A_ST, d); chk("R10 no status from writes", d, 32'd0);

        // R3 R4 R1: every pin, both polarities
        for (int p = 0; p < 36; p++) begin
            for (int pol = 0; pol < 2; pol++) begin
                expv = '0; expv[p] = 1'b1;
                pins[p] = pol[0];
                wait_n(4);
                wr(A_POL, pol[0] ? bankw(expv, 0) : 32'd0);
                wr(A_POL + 5'd4, pol[0] ? bankw(expv, 1) : 32'd0);
                wr(A_ST, '1); wr(A_ST + 5'd4, '1);
                wait_n(1);
                rd36(A_ST, d);        chk("R3 status quiet before edge", d, 32'd0);
                pins[p] = ~pol[0];
                wait_n(3);
                rd36(A_ST, d);        chk("R3 R1 low bank after edge", d, bankw(expv, 0));
                rd36(A_ST + 5'd4, d); chk("R3 R1 high bank after edge", d, bankw(expv, 1));
                chk("R4 irq stays low with enable clear", {31'd0, irq36}, 32'd0);
                pins[p] = pol[0];
                wait_n(3);
                rd36(A_ST, d);        chk("R4 sticky after opposite edge low", d, bankw(expv, 0));
                rd36(A_ST + 5'd4, d); chk("R4 sticky after opposite edge high", d, bankw(expv, 1));
            end
            pins[p] = 1'b0;
            wait_n(4);
        end
        wr(A_POL, 32'd0); wr(A_POL + 5'd4, 32'd0);
        wr(A_ST, '1); wr(A_ST + 5'd4, '1);

        // R6 R7: combined outputs
        pins[5] = 1'b1; pins[33] = 1'b1;
        wait_n(3);
        wr(A_EN, 32'h40);
        chk("R6 irq low for other enable", {31'd0, irq36}, 32'd0);
        wr(A_EN, 32'h20);
        chk("R6 irq high for matching enable", {31'd0, irq36}, 32'd1);
        wr(A_EN, 32'd0); wr(A_EN + 5'd4, 32'h2);
        chk("R6 irq high from high bank", {31'd0, irq36}, 32'd1);
        wr(A_WK + 5'd4, 32'h1);
        chk("R7 wake low for other pin", {31'd0, wake36}, 32'd0);
        wr(A_WK + 5'd4, 32'h2);
        chk("R7 wake high for matching pin", {31'd0, wake36}, 32'd1);
        wr(A_ST + 5'd4, 32'h2);
        chk("R7 wake low after clear", {31'd0, wake36}, 32'd0);
        chk("R6 irq low after clear", {31'd0, irq36}, 32'd0);
        wr(A_EN + 5'd4, 32'd0); wr(A_WK + 5'd4, 32'd0);

        // R5: write-one-to-clear semantics
        wr(A_ST, 32'd0);
        rd36(A_ST, d); chk("R5 write zero keeps bit", d, 32'h20);
        wr(A_ST, 32'h10);
        rd36(A_ST, d); chk("R5 clear of other bit keeps bit", d, 32'h20);
        pins[5] = 1'b0;
        wait_n(4);
        rd36(A_ST, d); chk("R3 falling edge ignored at polarity 0", d, 32'h20);
        pins[5] = 1'b1;
        wait_n(2);
        addr = A_ST; wdata = 32'h20; we = 1'b1;
        wait_n(1);
        we = 1'b0;
        rd36(A_ST, d); chk("R5 edge wins over same-cycle clear", d, 32'h20);
        wr(A_ST, 32'h20);
        rd36(A_ST, d); chk("R5 clear alone", d, 32'd0);
        pins[5] = 1'b0; pins[33] = 1'b0;
        wait_n(4);
        wr(A_ST, '1); wr(A_ST + 5'd4, '1);

        // R8: polarity flips on steady pins
        pins[2] = 1'b1;
        wait_n(4);
        wr(A_ST, '1);
        wr(A_POL, 32'h4); wait_n(4);
        rd36(A_ST, d); chk("R8 polarity to falling on high pin", d, 32'd0);
        wr(A_POL, 32'h0); wait_n(4);
        rd36(A_ST, d); chk("R8 polarity to rising on high pin", d, 32'd0);
        wr(A_POL + 5'd4, 32'h4); wait_n(4);
        wr(A_POL + 5'd4, 32'h0); wait_n(4);
        rd36(A_ST + 5'd4, d); chk("R8 polarity toggle on low pin", d, 32'd0);
        wr(A_POL, 32'h4);
        pins[2] = 1'b0;
        wait_n(3);
        rd36(A_ST, d); chk("R3 falling edge after polarity flip", d, 32'h4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule